// File: doc/BRIEF.md
# Calibration Code Source Selector

This block feeds a capacitive readout front end with every digital trim and configuration code it needs: a per-channel offset trim, a gain trim, the self-test DAC code, the charge-pump level, the pump oscillator's frequency choice and variable-frequency flag, and the temperature sensor's charge-current code. Each code exists twice. One copy sits in a frozen preset image that models the nonvolatile store and arrives as a wide read-only input vector. The other copy sits in a small shadow RAM that a host can rewrite at any time through an address, data and write-enable port.

Each sensor read command names a readout channel, a gain slot and a source bit. When the command is accepted, the block registers one complete set of codes. That set is taken either from the preset image or from the shadow RAM. It then holds the set unchanged until the next accepted command. A drifted channel can therefore be recalibrated in the field by rewriting RAM and reading with the RAM source, while the presets stay untouched.

Top module: `calsel_top`

## Requirements
- R1: While reset is high and on the first cycle after it, every code output is zero and `src_ram` is 0, so the preset source is indicated.
- R2: An accepted read with `cmd_use_ram`=0 sets the outputs on the following clock edge from the preset image. Offset of channel c is at bits [8c+7:8c]. Gain of slot g is at [40+10g+9:40+10g]. DAC is at [75:70], pump level at [78:76], oscillator frequency at [80:79], variable-frequency flag at bit 81 and temperature code at [85:82].
- R3: An accepted read with `cmd_use_ram`=1 sets the outputs on the following edge from shadow RAM. Words 0..4 hold channel offsets in bits [7:0]. Words 5..7 hold gain slots 0..2 in bits [9:0]. Word 8 holds the DAC code in bits [5:0]. Word 10 holds the temperature code in bits [3:0].
- R4: The offset output belongs to the channel named by `cmd_ch` (0..4) and the gain output to the slot named by `cmd_gsel` (0..2).
- R5: Between accepted reads the outputs do not change, whatever RAM writes or preset image changes happen.
- R6: A read with `cmd_ch` of 5 or more, or `cmd_gsel` of 3, is ignored: all outputs and `src_ram` keep their values.
- R7: Writes to RAM addresses 11..15 are ignored; a later RAM read of every mapped word returns the earlier contents.
- R8: RAM writes never alter the preset values; a preset read after any writes returns the image fields.
- R9: When a RAM write and an accepted RAM read fall in the same cycle, the read returns the word's value from before the write, and the next read returns the new value.
- R10: `src_ram` shows the source bit of the most recently accepted read.
- R11: RAM word 9 packs the pump settings: level in bits [2:0], oscillator frequency choice in bits [4:3] and variable-frequency flag in bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nv_image | input | 86 | Preset image (read-only model of the nonvolatile store) |
| ram_we | input | 1 | Shadow RAM write enable |
| ram_addr | input | 4 | Shadow RAM word address |
| ram_wdata | input | 10 | Shadow RAM write data |
| cmd_valid | input | 1 | Read command strobe |
| cmd_ch | input | 3 | Readout channel of the command |
| cmd_gsel | input | 2 | Gain slot of the command |
| cmd_use_ram | input | 1 | Source bit: 0 preset, 1 shadow RAM |
| ofs_code | output | 8 | Offset trim code |
| gain_code | output | 10 | Gain trim code |
| dac_code | output | 6 | Self-test DAC code |
| pump_lvl | output | 3 | Charge-pump level select |
| osc_freq | output | 2 | Pump oscillator fixed-frequency choice |
| osc_var | output | 1 | Pump oscillator variable-frequency flag |
| temp_code | output | 4 | Temperature sensor current code |
| src_ram | output | 1 | Source of the held code set |

## Verification
A shadow RAM write and a RAM-sourced read command can land on the same clock edge and touch the same word. The bench provokes this by driving a write to the offset word of channel 2 together with a RAM read of channel 2. It expects the pre-write offset on the outputs, and then issues a second read that must show the written value. The held-output rule is judged against the same collision class, because writes and preset image changes made between reads must leave the outputs untouched.

// File: rtl/calsel_pkg.sv
package calsel_pkg;
  // default field geometry of the front end
  localparam int DEF_NUM_CH   = 5;
  localparam int DEF_NUM_GAIN = 3;
  localparam int DEF_OFS_W    = 8;
  localparam int DEF_GAIN_W   = 10;
  localparam int DEF_DAC_W    = 6;
  localparam int DEF_PUMP_W   = 3;
  localparam int DEF_FREQ_W   = 2;
  localparam int DEF_TEMP_W   = 4;

  typedef enum logic {SRC_NV = 1'b0, SRC_RAM = 1'b1} cal_src_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/calsel_nv_view.sv
module calsel_nv_view #(
  parameter int NUM_CH   = 5,
  parameter int NUM_GAIN = 3,
  parameter int OFS_W    = 8,
  parameter int GAIN_W   = 10,
  parameter int DAC_W    = 6,
  parameter int PUMP_W   = 3,
  parameter int FREQ_W   = 2,
  parameter int TEMP_W   = 4,
  localparam int CH_W      = $clog2(NUM_CH),
  localparam int GS_W      = $clog2(NUM_GAIN),
  localparam int GAIN_BASE = NUM_CH * OFS_W,
  localparam int DAC_BASE  = GAIN_BASE + NUM_GAIN * GAIN_W,
  localparam int PUMP_BASE = DAC_BASE + DAC_W,
  localparam int FREQ_BASE = PUMP_BASE + PUMP_W,
  localparam int VAR_BASE  = FREQ_BASE + FREQ_W,
  localparam int TEMP_BASE = VAR_BASE + 1,
  localparam int IMG_W     = TEMP_BASE + TEMP_W
) (
  input  logic [IMG_W-1:0]  image,
  input  logic [CH_W-1:0]   ch,
  input  logic [GS_W-1:0]   gsel,
  output logic [OFS_W-1:0]  ofs,
  output logic [GAIN_W-1:0] gain,
  output logic [DAC_W-1:0]  dac,
  output logic [PUMP_W-1:0] pump,
  output logic [FREQ_W-1:0] freq,
  output logic              fvar,
  output logic [TEMP_W-1:0] temp
);
  logic [OFS_W-1:0]  ofs_arr  [NUM_CH];
  logic [GAIN_W-1:0] gain_arr [NUM_GAIN];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ofs
    assign ofs_arr[i] = image[i*OFS_W +: OFS_W];
  end
  for (genvar j = 0; j < NUM_GAIN; j++) begin : g_gain
    assign gain_arr[j] = image[GAIN_BASE + j*GAIN_W +: GAIN_W];
  end

  always_comb begin
    ofs  = (ch < CH_W'(NUM_CH))     ? ofs_arr[ch]    : '0;
    gain = (gsel < GS_W'(NUM_GAIN)) ? gain_arr[gsel] : '0;
  end

  assign dac  = image[DAC_BASE  +: DAC_W];
  assign pump = image[PUMP_BASE +: PUMP_W];
  assign freq = image[FREQ_BASE +: FREQ_W];
  assign fvar = image[VAR_BASE];
  assign temp = image[TEMP_BASE +: TEMP_W];
endmodule

// File: rtl/calsel_shadow.sv
module calsel_shadow #(
  parameter int NUM_CH   = 5,
  parameter int NUM_GAIN = 3,
  parameter int OFS_W    = 8,
  parameter int GAIN_W   = 10,
  parameter int DAC_W    = 6,
  parameter int PUMP_W   = 3,
  parameter int FREQ_W   = 2,
  parameter int TEMP_W   = 4,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int GS_W   = $clog2(NUM_GAIN),
  localparam int NWORDS = NUM_CH + NUM_GAIN + 3,
  localparam int AW     = $clog2(NWORDS),
  localparam int DW     = calsel_pkg::max_of(calsel_pkg::max_of(OFS_W, GAIN_W),
                            calsel_pkg::max_of(calsel_pkg::max_of(DAC_W, TEMP_W),
                                               PUMP_W + FREQ_W + 1))
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DW-1:0]     wdata,
  input  logic [CH_W-1:0]   ch,
  input  logic [GS_W-1:0]   gsel,
  output logic [OFS_W-1:0]  ofs,
  output logic [GAIN_W-1:0] gain,
  output logic [DAC_W-1:0]  dac,
  output logic [PUMP_W-1:0] pump,
  output logic [FREQ_W-1:0] freq,
  output logic              fvar,
  output logic [TEMP_W-1:0] temp
);
  localparam int A_GAIN = NUM_CH;
  localparam int A_DAC  = NUM_CH + NUM_GAIN;
  localparam int A_PUMP = A_DAC + 1;
  localparam int A_TEMP = A_DAC + 2;

  logic [DW-1:0] mem [NWORDS];
  logic          addr_ok;
  logic [DW-1:0] ofs_word, gain_word, pump_word;

  assign addr_ok = ({1'b0, waddr} < (AW+1)'(NWORDS));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NWORDS; i++) mem[i] <= '0;
    end else if (we && addr_ok) begin
      mem[waddr] <= wdata;
    end
  end

  always_comb begin
    ofs_word  = (ch < CH_W'(NUM_CH))     ? mem[AW'(ch)] : '0;
    gain_word = (gsel < GS_W'(NUM_GAIN)) ? mem[AW'(A_GAIN) + AW'(gsel)] : '0;
    pump_word = mem[A_PUMP];
  end

  assign ofs  = ofs_word[OFS_W-1:0];
  assign gain = gain_word[GAIN_W-1:0];
  assign dac  = mem[A_DAC][DAC_W-1:0];
  assign pump = pump_word[PUMP_W-1:0];
  assign freq = pump_word[PUMP_W +: FREQ_W];
  assign fvar = pump_word[PUMP_W + FREQ_W];
  assign temp = mem[A_TEMP][TEMP_W-1:0];
endmodule

// File: rtl/calsel_hold.sv
module calsel_hold #(
  parameter int OFS_W  = 8,
  parameter int GAIN_W = 10,
  parameter int DAC_W  = 6,
  parameter int PUMP_W = 3,
  parameter int FREQ_W = 2,
  parameter int TEMP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              use_ram,
  input  logic [OFS_W-1:0]  nv_ofs,
  input  logic [GAIN_W-1:0] nv_gain,
  input  logic [DAC_W-1:0]  nv_dac,
  input  logic [PUMP_W-1:0] nv_pump,
  input  logic [FREQ_W-1:0] nv_freq,
  input  logic              nv_fvar,
  input  logic [TEMP_W-1:0] nv_temp,
  input  logic [OFS_W-1:0]  rm_ofs,
  input  logic [GAIN_W-1:0] rm_gain,
  input  logic [DAC_W-1:0]  rm_dac,
  input  logic [PUMP_W-1:0] rm_pump,
  input  logic [FREQ_W-1:0] rm_freq,
  input  logic              rm_fvar,
  input  logic [TEMP_W-1:0] rm_temp,
  output logic [OFS_W-1:0]  ofs_q,
  output logic [GAIN_W-1:0] gain_q,
  output logic [DAC_W-1:0]  dac_q,
  output logic [PUMP_W-1:0] pump_q,
  output logic [FREQ_W-1:0] freq_q,
  output logic              fvar_q,
  output logic [TEMP_W-1:0] temp_q,
  output calsel_pkg::cal_src_e src_q
);
  import calsel_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      ofs_q  <= '0;
      gain_q <= '0;
      dac_q  <= '0;
      pump_q <= '0;
      freq_q <= '0;
      fvar_q <= 1'b0;
      temp_q <= '0;
      src_q  <= SRC_NV;
    end else if (load) begin
      if (use_ram) begin
        ofs_q  <= rm_ofs;
        gain_q <= rm_gain;
        dac_q  <= rm_dac;
        pump_q <= rm_pump;
        freq_q <= rm_freq;
        fvar_q <= rm_fvar;
        temp_q <= rm_temp;
        src_q  <= SRC_RAM;
      end else begin
        ofs_q  <= nv_ofs;
        gain_q <= nv_gain;
        dac_q  <= nv_dac;
        pump_q <= nv_pump;
        freq_q <= nv_freq;
        fvar_q <= nv_fvar;
        temp_q <= nv_temp;
        src_q  <= SRC_NV;
      end
    end
  end
endmodule

// File: rtl/calsel_top.sv
module calsel_top #(
  parameter int NUM_CH   = calsel_pkg::DEF_NUM_CH,
  parameter int NUM_GAIN = calsel_pkg::DEF_NUM_GAIN,
  parameter int OFS_W    = calsel_pkg::DEF_OFS_W,
  parameter int GAIN_W   = calsel_pkg::DEF_GAIN_W,
  parameter int DAC_W    = calsel_pkg::DEF_DAC_W,
  parameter int PUMP_W   = calsel_pkg::DEF_PUMP_W,
  parameter int FREQ_W   = calsel_pkg::DEF_FREQ_W,
  parameter int TEMP_W   = calsel_pkg::DEF_TEMP_W,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int GS_W   = $clog2(NUM_GAIN),
  localparam int IMG_W  = NUM_CH*OFS_W + NUM_GAIN*GAIN_W + DAC_W + PUMP_W + FREQ_W + 1 + TEMP_W,
  localparam int NWORDS = NUM_CH + NUM_GAIN + 3,
  localparam int AW     = $clog2(NWORDS),
  localparam int DW     = calsel_pkg::max_of(calsel_pkg::max_of(OFS_W, GAIN_W),
                            calsel_pkg::max_of(calsel_pkg::max_of(DAC_W, TEMP_W),
                                               PUMP_W + FREQ_W + 1))
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IMG_W-1:0]  nv_image,
  input  logic              ram_we,
  input  logic [AW-1:0]     ram_addr,
  input  logic [DW-1:0]     ram_wdata,
  input  logic              cmd_valid,
  input  logic [CH_W-1:0]   cmd_ch,
  input  logic [GS_W-1:0]   cmd_gsel,
  input  logic              cmd_use_ram,
  output logic [OFS_W-1:0]  ofs_code,
  output logic [GAIN_W-1:0] gain_code,
  output logic [DAC_W-1:0]  dac_code,
  output logic [PUMP_W-1:0] pump_lvl,
  output logic [FREQ_W-1:0] osc_freq,
  output logic              osc_var,
  output logic [TEMP_W-1:0] temp_code,
  output logic              src_ram
);
  import calsel_pkg::*;

  logic [OFS_W-1:0]  nv_ofs,  rm_ofs;
  logic [GAIN_W-1:0] nv_gain, rm_gain;
  logic [DAC_W-1:0]  nv_dac,  rm_dac;
  logic [PUMP_W-1:0] nv_pump, rm_pump;
  logic [FREQ_W-1:0] nv_freq, rm_freq;
  logic              nv_fvar, rm_fvar;
  logic [TEMP_W-1:0] nv_temp, rm_temp;
  logic              cmd_take;
  cal_src_e          src_q;

  assign cmd_take = cmd_valid && (cmd_ch < CH_W'(NUM_CH)) && (cmd_gsel < GS_W'(NUM_GAIN));

  calsel_nv_view #(
    .NUM_CH(NUM_CH), .NUM_GAIN(NUM_GAIN), .OFS_W(OFS_W), .GAIN_W(GAIN_W),
    .DAC_W(DAC_W), .PUMP_W(PUMP_W), .FREQ_W(FREQ_W), .TEMP_W(TEMP_W)
  ) nv_i (
    .image(nv_image), .ch(cmd_ch), .gsel(cmd_gsel),
    .ofs(nv_ofs), .gain(nv_gain), .dac(nv_dac), .pump(nv_pump),
    .freq(nv_freq), .fvar(nv_fvar), .temp(nv_temp)
  );

  calsel_shadow #(
    .NUM_CH(NUM_CH), .NUM_GAIN(NUM_GAIN), .OFS_W(OFS_W), .GAIN_W(GAIN_W),
    .DAC_W(DAC_W), .PUMP_W(PUMP_W), .FREQ_W(FREQ_W), .TEMP_W(TEMP_W)
  ) ram_i (
    .clk(clk), .rst(rst), .we(ram_we), .waddr(ram_addr), .wdata(ram_wdata),
    .ch(cmd_ch), .gsel(cmd_gsel),
    .ofs(rm_ofs), .gain(rm_gain), .dac(rm_dac), .pump(rm_pump),
    .freq(rm_freq), .fvar(rm_fvar), .temp(rm_temp)
  );

  calsel_hold #(
    .OFS_W(OFS_W), .GAIN_W(GAIN_W), .DAC_W(DAC_W),
    .PUMP_W(PUMP_W), .FREQ_W(FREQ_W), .TEMP_W(TEMP_W)
  ) hold_i (
    .clk(clk), .rst(rst), .load(cmd_take), .use_ram(cmd_use_ram),
    .nv_ofs(nv_ofs), .nv_gain(nv_gain), .nv_dac(nv_dac), .nv_pump(nv_pump),
    .nv_freq(nv_freq), .nv_fvar(nv_fvar), .nv_temp(nv_temp),
    .rm_ofs(rm_ofs), .rm_gain(rm_gain), .rm_dac(rm_dac), .rm_pump(rm_pump),
    .rm_freq(rm_freq), .rm_fvar(rm_fvar), .rm_temp(rm_temp),
    .ofs_q(ofs_code), .gain_q(gain_code), .dac_q(dac_code), .pump_q(pump_lvl),
    .freq_q(osc_freq), .fvar_q(osc_var), .temp_q(temp_code), .src_q(src_q)
  );

  assign src_ram = (src_q == SRC_RAM);
endmodule

// File: rtl/calsel_chk.sv
module calsel_chk #(
  parameter int NUM_CH   = 5,
  parameter int NUM_GAIN = 3,
  parameter int OFS_W    = 8,
  parameter int GAIN_W   = 10,
  parameter int DAC_W    = 6,
  parameter int PUMP_W   = 3,
  parameter int FREQ_W   = 2,
  parameter int TEMP_W   = 4,
  localparam int CH_W     = $clog2(NUM_CH),
  localparam int GS_W     = $clog2(NUM_GAIN),
  localparam int DAC_BASE = NUM_CH*OFS_W + NUM_GAIN*GAIN_W,
  localparam int IMG_W    = DAC_BASE + DAC_W + PUMP_W + FREQ_W + 1 + TEMP_W
) (
  input logic              clk,
  input logic              rst,
  input logic [IMG_W-1:0]  nv_image,
  input logic              cmd_valid,
  input logic [CH_W-1:0]   cmd_ch,
  input logic [GS_W-1:0]   cmd_gsel,
  input logic              cmd_use_ram,
  input logic [OFS_W-1:0]  ofs_code,
  input logic [GAIN_W-1:0] gain_code,
  input logic [DAC_W-1:0]  dac_code,
  input logic [PUMP_W-1:0] pump_lvl,
  input logic [FREQ_W-1:0] osc_freq,
  input logic              osc_var,
  input logic [TEMP_W-1:0] temp_code,
  input logic              src_ram
);
  logic             acc;
  logic [IMG_W-1:0] ofs_shift;

  assign acc       = cmd_valid && (cmd_ch < CH_W'(NUM_CH)) && (cmd_gsel < GS_W'(NUM_GAIN));
  assign ofs_shift = nv_image >> (int'(cmd_ch) * OFS_W);

  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (!src_ram && ofs_code == '0 && gain_code == '0 && dac_code == '0));

  // R5
  hold_codes_chk: assert property (@(posedge clk) disable iff (rst)
    !acc |=> $stable({ofs_code, gain_code, dac_code, pump_lvl, osc_freq, osc_var, temp_code, src_ram}));

  // R10
  src_follow_chk: assert property (@(posedge clk) disable iff (rst)
    acc |=> (src_ram == $past(cmd_use_ram)));

  // R2
  nv_dac_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && !cmd_use_ram) |=> (dac_code == $past(nv_image[DAC_BASE +: DAC_W])));

  // R4
  nv_ofs_chk: assert property (@(posedge clk) disable iff (rst)
    (acc && !cmd_use_ram) |=> (ofs_code == $past(ofs_shift[OFS_W-1:0])));
endmodule

bind calsel_top calsel_chk #(
  .NUM_CH(NUM_CH), .NUM_GAIN(NUM_GAIN), .OFS_W(OFS_W), .GAIN_W(GAIN_W),
  .DAC_W(DAC_W), .PUMP_W(PUMP_W), .FREQ_W(FREQ_W), .TEMP_W(TEMP_W)
) chk_i (
  .clk(clk), .rst(rst), .nv_image(nv_image), .cmd_valid(cmd_valid),
  .cmd_ch(cmd_ch), .cmd_gsel(cmd_gsel), .cmd_use_ram(cmd_use_ram),
  .ofs_code(ofs_code), .gain_code(gain_code), .dac_code(dac_code),
  .pump_lvl(pump_lvl), .osc_freq(osc_freq), .osc_var(osc_var),
  .temp_code(temp_code), .src_ram(src_ram)
);

// File: tb/calsel_top_tb.sv
module calsel_top_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [85:0] nv_image = '0;
  logic        ram_we = 1'b0;
  logic [3:0]  ram_addr = '0;
  logic [9:0]  ram_wdata = '0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_ch = '0;
  logic [1:0]  cmd_gsel = '0;
  logic        cmd_use_ram = 1'b0;
  logic [7:0]  ofs_code;
  logic [9:0]  gain_code;
  logic [5:0]  dac_code;
  logic [2:0]  pump_lvl;
  logic [1:0]  osc_freq;
  logic        osc_var;
  logic [3:0]  temp_code;
  logic        src_ram;

  calsel_top dut_i (
    .clk(clk), .rst(rst), .nv_image(nv_image), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .cmd_valid(cmd_valid),
    .cmd_ch(cmd_ch), .cmd_gsel(cmd_gsel), .cmd_use_ram(cmd_use_ram),
    .ofs_code(ofs_code), .gain_code(gain_code), .dac_code(dac_code),
    .pump_lvl(pump_lvl), .osc_freq(osc_freq), .osc_var(osc_var),
    .temp_code(temp_code), .src_ram(src_ram)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench-side models of the preset fields and of the shadow RAM
  logic [7:0] m_ofs [5];
  logic [9:0] m_gain [3];
  logic [5:0] m_dac;
  logic [2:0] m_pump;
  logic [1:0] m_freq;
  logic       m_var;
  logic [3:0] m_temp;
  logic [9:0] m_ram [11];

  logic [34:0] exp_q [$];
  string       tag_q [$];
  logic [34:0] cur_exp = '0;

  wire [34:0] act = {ofs_code, gain_code, dac_code, pump_lvl, osc_freq, osc_var, temp_code, src_ram};

  function automatic logic [85:0] pack_image();
    logic [85:0] img = '0;
    for (int i = 0; i < 5; i++) img[i*8 +: 8] = m_ofs[i];
    for (int j = 0; j < 3; j++) img[40 + j*10 +: 10] = m_gain[j];
    img[75:70] = m_dac;
    img[78:76] = m_pump;
    img[80:79] = m_freq;
    img[81]    = m_var;
    img[85:82] = m_temp;
    return img;
  endfunction

  function automatic logic [34:0] model_exp(input int ch, input int g, input bit ram);
    if (ram)
      return {m_ram[ch][7:0], m_ram[5+g], m_ram[8][5:0], m_ram[9][2:0],
              m_ram[9][4:3], m_ram[9][5], m_ram[10][3:0], 1'b1};
    return {m_ofs[ch], m_gain[g], m_dac, m_pump, m_freq, m_var, m_temp, 1'b0};
  endfunction

  task automatic check_now(input string tag, input logic [34:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  // monitor: pops one expectation per presented command
  initial begin
    forever begin
      @(posedge clk);
      if (!rst && cmd_valid) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL monitor: result with empty queue actual=%h expected=none", act);
        end else begin
          check_now(tag_q.pop_front(), exp_q.pop_front());
        end
      end
    end
  end

  task automatic wr(input int addr, input logic [9:0] data);
    ram_we = 1'b1; ram_addr = 4'(addr); ram_wdata = data;
    @(negedge clk);
    ram_we = 1'b0;
    if (addr < 11) m_ram[addr] = data;
  endtask

  task automatic rd(input int ch, input int g, input bit ram, input string tag);
    cmd_valid = 1'b1; cmd_ch = 3'(ch); cmd_gsel = 2'(g); cmd_use_ram = ram;
    if (ch < 5 && g < 3) cur_exp = model_exp(ch, g, ram);
    exp_q.push_back(cur_exp);
    tag_q.push_back(tag);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: run hung actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 5; i++) m_ofs[i] = 8'(8'hA1 + i*23);
    for (int j = 0; j < 3; j++) m_gain[j] = 10'(10'h2C5 + j*77);
    m_dac = 6'h2B; m_pump = 3'd5; m_freq = 2'd2; m_var = 1'b1; m_temp = 4'hB;
    for (int k = 0; k < 11; k++) m_ram[k] = '0;
    nv_image = pack_image();

    repeat (3) @(negedge clk);
    check_now("R1 outputs during reset", 35'd0);
    rst = 1'b0;
    @(negedge clk);
    check_now("R1 outputs after reset", 35'd0);

    // fill shadow RAM
    for (int k = 0; k < 5; k++) wr(k, 10'(10'h055 + k*13));
    for (int k = 5; k < 8; k++) wr(k, 10'(10'h1F0 + k*29));
    wr(8, 10'h01C);
    wr(9, {4'b0, 1'b0, 2'd1, 3'd6});
    wr(10, 10'h006);

    // preset reads over all channels and slots
    for (int c = 0; c < 5; c++) rd(c, c % 3, 1'b0, "R2 R4 preset read");
    // RAM reads over all channels and slots
    for (int c = 0; c < 5; c++) rd(c, (c + 1) % 3, 1'b1, "R3 R4 R11 RAM read");
    wr(9, {4'b0, 1'b1, 2'd3, 3'd2});
    rd(3, 2, 1'b1, "R11 pump word repacked");

    // alternating sources
    rd(1, 0, 1'b0, "R10 back to preset");
    rd(1, 0, 1'b1, "R10 to RAM");

    // ignored commands
    rd(5, 0, 1'b0, "R6 channel 5");
    rd(7, 1, 1'b0, "R6 channel 7");
    rd(2, 3, 1'b0, "R6 gain slot 3");

    // hold between reads
    wr(0, 10'h3FF);
    wr(6, 10'h000);
    m_dac = 6'h11;
    nv_image = pack_image();
    @(negedge clk);
    check_now("R5 hold after writes and image change", cur_exp);
    m_dac = 6'h2B;
    nv_image = pack_image();

    // unmapped writes
    for (int a = 11; a < 16; a++) wr(a, 10'h2AA);
    for (int c = 0; c < 5; c++) rd(c, c % 3, 1'b1, "R7 mapped words intact");
    rd(4, 2, 1'b1, "R7 gain slot 2 intact");

    // presets unaffected by writes
    for (int c = 0; c < 5; c++) rd(c, 2 - (c % 3), 1'b0, "R8 preset after writes");

    // write and read colliding on one edge
    ram_we = 1'b1; ram_addr = 4'd2; ram_wdata = 10'h0E7;
    cmd_valid = 1'b1; cmd_ch = 3'd2; cmd_gsel = 2'd1; cmd_use_ram = 1'b1;
    cur_exp = model_exp(2, 1, 1'b1);
    exp_q.push_back(cur_exp);
    tag_q.push_back("R9 same-cycle read sees old word");
    @(negedge clk);
    ram_we = 1'b0; cmd_valid = 1'b0;
    m_ram[2] = 10'h0E7;
    rd(2, 1, 1'b1, "R9 next read sees new word");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard drain actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule